// File: doc/BRIEF.md
# Serial Presence-Detect EEPROM Target

This block is the slave side of a two-wire I2C bus that answers as a 256-byte presence-detect memory on a memory module. A bus master addresses it with a seven-bit device address. The top four bits of that address are fixed at 1010 and the low three come from strap pins, so up to eight such targets can share one bus. The master loads an internal byte pointer with a write transfer. It can then store bytes at the pointer, or issue a repeated START with a read address and stream bytes out from the pointer. The target keeps sending for as long as the master acknowledges each byte.

Both bus lines are sampled in the system clock domain. Each passes through a two-flop synchroniser and a short glitch filter before START, STOP and clock edges are found. The target drives the data line only as an open-drain pull-down enable. After a STOP that closes a transfer which stored data, the target ignores its own address for a parameterised number of system clocks. This stands in for the non-volatile write time. The contents reset to a fixed module description that carries a checksum byte.

Top module: `spd_i2c_target`

## Requirements
- R1: After reset the pull-down enable is low, and the byte pointer is 0, so a read issued before any pointer write starts at byte 0.
- R2: After reset the memory holds these values. Byte 0 is 0x80, byte 1 is 0x08 and byte 2 is 0x02. Bytes 3 and 4 are 0x0A, byte 5 is 0x01, byte 6 is 0x40, byte 8 is 0x01, byte 9 is 0x3C, byte 10 is 0x0F and byte 13 is 0x10. The other bytes below 63 are 0x00. Byte 63 is the low 8 bits of the sum of bytes 0 to 62. Each byte at index 64 or above is that index XOR 0xA5.
- R3: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Before a START, any clocked bits are ignored and SDA is never pulled low. A STOP returns the target to idle with SDA released.
- R4: After START, the first byte is received MSB first as address[6:0] followed by a direction bit, where 1 means read. The target pulls SDA low on the ninth clock only when address[6:3] is 1010 and address[2:0] equals the straps. Otherwise it stays released until the next START or STOP.
- R5: In a write transfer, the first byte after the address loads the pointer. Each later byte is stored at the pointer, and the pointer then increments. The target acknowledges every one of these bytes on the ninth clock.
- R6: A read transfer sends the byte at the pointer MSB first and then increments the pointer. It sends the following byte each time the master pulls SDA low on the ninth clock. The pointer wraps from 255 to 0.
- R7: When the master leaves SDA high on the ninth clock of a read, the target stops sending and keeps SDA released for any further clocks until START or STOP.
- R8: After a STOP that ends a transfer in which at least one data byte was stored, the target does not acknowledge its address for BUSY_CYCLES system clocks. After that window it acknowledges again. A transfer that only loads the pointer starts no busy window.
- R9: The pull-down enable changes only while the filtered SCL is low.
- R10: A level on SCL or SDA that lasts fewer than FILT_LEN system clocks is ignored. For example, a short low pulse on SDA with SCL high is not taken as a START.
- R11: A STOP in the middle of a data byte discards the partial byte. Bytes that were completed earlier in the same transfer stay stored and start the busy window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad (wired-AND level) |
| strap_i | input | 3 | Low three device address bits |
| sda_drive_low_o | output | 1 | When high, the pad pulls SDA low; when low, SDA is released |

## Verification
The assertions watch the per-cycle rules of the protocol engine on every clock. The pull-down enable moves only while SCL is low, and a STOP always lands in idle with the line released. An address acknowledge never happens while the busy window is running or on a wrong device address, and the target never drives while it is waiting after a NACK. The filter output only ever takes a level that the synchronised input actually held, and a completed write always lands in the array. The bench's scenarios are the only way to show the rest: the reset contents and checksum, pointer loading and wrap, the byte sequence of a streamed read, and the timing of the busy window. They also cover glitch rejection and the discarding of a byte cut short by a STOP.

// File: rtl/spd_pkg.sv
// Package: shared state encoding, device type code and reset contents
// of the presence-detect memory. Assumes a 256-entry byte array.
package spd_pkg;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_PTR, ST_PTR_ACK,
        ST_WDATA, ST_WD_ACK, ST_RD, ST_RACK, ST_WAIT
    } spd_state_e;

    // Description byte for one index, checksum slot excluded.
    function automatic logic [7:0] spd_field(input int unsigned idx);
        case (idx)
            0:       return 8'h80;
            1:       return 8'h08;
            2:       return 8'h02;
            3, 4:    return 8'h0A;
            5:       return 8'h01;
            6:       return 8'h40;
            8:       return 8'h01;
            9:       return 8'h3C;
            10:      return 8'h0F;
            13:      return 8'h10;
            default: return (idx >= 64) ? (8'(idx) ^ 8'hA5) : 8'h00;
        endcase
    endfunction

    // Reset value of one byte; index 63 carries the sum of 0..62.
    function automatic logic [7:0] spd_preset(input int unsigned idx);
        logic [7:0] sum;
        sum = 8'h00;
        if (idx == 63) begin
            for (int unsigned j = 0; j < 63; j++) sum = sum + spd_field(j);
            return sum;
        end
        return spd_field(idx);
    endfunction

endpackage

// File: rtl/spd_line_filter.sv
// Line conditioner: two-flop synchroniser followed by a majority-free
// glitch filter. The output follows the input only after FILT_LEN
// consecutive equal synchronised samples. Idle bus level is high.
module spd_line_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    logic [1:0]          sync_q;
    logic [FILT_LEN-1:0] hist_q;

    // Synchronise, keep a sample history, update on a unanimous history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
            filt_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw_i};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
            if (&hist_q)       filt_o <= 1'b1;
            else if (~|hist_q) filt_o <= 1'b0;
        end
    end

    // R10: a new filtered level is one the synchronised line really held.
    a_r10_filter_tracks_line: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_o) |-> (filt_o == $past(sync_q[1], 2)));

endmodule

// File: rtl/spd_store.sv
// Byte array of the presence-detect contents. Synchronous write port,
// combinational read port. Reset reloads the description bytes.
module spd_store #(
    parameter int DEPTH = 256,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wr_data_i,
    output logic [7:0]        rd_data_o
);
    import spd_pkg::*;

    logic [7:0] mem_q [DEPTH];

    // Preload on reset, otherwise store one byte per write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= spd_preset(i);
        end else if (wr_en_i) begin
            mem_q[addr_i] <= wr_data_i;
        end
    end

    assign rd_data_o = mem_q[addr_i];

    // R5: a strobed byte is present in the array on the next cycle.
    a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (mem_q[$past(addr_i)] == $past(wr_data_i)));

endmodule

// File: rtl/spd_proto_fsm.sv
// Bus protocol engine: finds START/STOP and SCL edges on the filtered
// lines, decodes the device address, runs pointer load, byte writes and
// streamed reads, and times the post-write busy window. Samples SDA on
// SCL rise and changes its drive only after SCL fall. Straps are static.
module spd_proto_fsm #(
    parameter int ADDR_W      = 8,
    parameter int BUSY_CYCLES = 3_750_000,
    localparam int BUSY_W     = $clog2(BUSY_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_f_i,
    input  logic              sda_f_i,
    input  logic [2:0]        strap_i,
    input  logic [7:0]        rd_data_i,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              wr_en_o,
    output logic [7:0]        wr_data_o,
    output logic              drive_low_o
);
    import spd_pkg::*;

    spd_state_e        state_q;
    logic              scl_q, sda_q;
    logic [3:0]        cnt_q;
    logic [7:0]        shreg_q, tx_q;
    logic              rw_q, wrote_q, mack_q;
    logic [BUSY_W-1:0] busy_q;
    logic              scl_rise, scl_fall, start_det, stop_det, rx_state, byte_done;

    // Delayed copies of the filtered lines for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f_i;
            sda_q <= sda_f_i;
        end
    end

    assign scl_rise  = scl_f_i & ~scl_q;
    assign scl_fall  = ~scl_f_i & scl_q;
    assign start_det = scl_f_i & scl_q & sda_q & ~sda_f_i;
    assign stop_det  = scl_f_i & scl_q & ~sda_q & sda_f_i;
    assign rx_state  = (state_q == ST_ADDR) || (state_q == ST_PTR) || (state_q == ST_WDATA);
    assign byte_done = (cnt_q == 4'd8);
    assign wr_en_o   = (state_q == ST_WDATA) && scl_fall && byte_done;
    assign wr_data_o = shreg_q;

    // Protocol sequencing, pointer, transmit shifter and busy timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cnt_q       <= '0;
            shreg_q     <= '0;
            tx_q        <= '0;
            ptr_o       <= '0;
            rw_q        <= 1'b0;
            wrote_q     <= 1'b0;
            mack_q      <= 1'b0;
            busy_q      <= '0;
            drive_low_o <= 1'b0;
        end else begin
            if (busy_q != '0) busy_q <= busy_q - 1'b1;
            if (start_det) begin
                state_q     <= ST_ADDR;
                cnt_q       <= '0;
                drive_low_o <= 1'b0;
            end else if (stop_det) begin
                state_q     <= ST_IDLE;
                drive_low_o <= 1'b0;
                wrote_q     <= 1'b0;
                if (wrote_q) busy_q <= BUSY_W'(BUSY_CYCLES);
            end else if (scl_rise) begin
                if (rx_state) begin
                    shreg_q <= {shreg_q[6:0], sda_f_i};
                    cnt_q   <= cnt_q + 1'b1;
                end
                if (state_q == ST_RACK) mack_q <= ~sda_f_i;
            end else if (scl_fall) begin
                case (state_q)
                    ST_ADDR: if (byte_done) begin
                        if (shreg_q[7:1] == {DEV_TYPE, strap_i} && busy_q == '0) begin
                            drive_low_o <= 1'b1;
                            rw_q        <= shreg_q[0];
                            state_q     <= ST_ADDR_ACK;
                        end else begin
                            state_q <= ST_WAIT;
                        end
                    end
                    ST_ADDR_ACK: begin
                        cnt_q <= '0;
                        if (rw_q) begin
                            tx_q        <= {rd_data_i[6:0], 1'b0};
                            drive_low_o <= ~rd_data_i[7];
                            ptr_o       <= ptr_o + 1'b1;
                            cnt_q       <= 4'd1;
                            state_q     <= ST_RD;
                        end else begin
                            drive_low_o <= 1'b0;
                            state_q     <= ST_PTR;
                        end
                    end
                    ST_PTR: if (byte_done) begin
                        ptr_o       <= ADDR_W'(shreg_q);
                        drive_low_o <= 1'b1;
                        state_q     <= ST_PTR_ACK;
                    end
                    ST_WDATA: if (byte_done) begin
                        ptr_o       <= ptr_o + 1'b1;
                        wrote_q     <= 1'b1;
                        drive_low_o <= 1'b1;
                        state_q     <= ST_WD_ACK;
                    end
                    ST_PTR_ACK, ST_WD_ACK: begin
                        drive_low_o <= 1'b0;
                        cnt_q       <= '0;
                        state_q     <= ST_WDATA;
                    end
                    ST_RD: begin
                        if (byte_done) begin
                            drive_low_o <= 1'b0;
                            state_q     <= ST_RACK;
                        end else begin
                            drive_low_o <= ~tx_q[7];
                            tx_q        <= {tx_q[6:0], 1'b0};
                            cnt_q       <= cnt_q + 1'b1;
                        end
                    end
                    ST_RACK: begin
                        if (mack_q) begin
                            tx_q        <= {rd_data_i[6:0], 1'b0};
                            drive_low_o <= ~rd_data_i[7];
                            ptr_o       <= ptr_o + 1'b1;
                            cnt_q       <= 4'd1;
                            state_q     <= ST_RD;
                        end else begin
                            state_q <= ST_WAIT;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R9: the pull-down enable never moves while SCL is high.
    a_r9_drive_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(drive_low_o) |-> !scl_f_i);

    // R3: a STOP leaves the engine idle with SDA released.
    a_r3_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state_q == ST_IDLE) && !drive_low_o);

    // R8: no address acknowledge while the busy window runs.
    a_r8_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR_ACK) |-> (busy_q == '0));

    // R4: an address acknowledge only for the strapped device address.
    a_r4_ack_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR_ACK) |-> (shreg_q[7:1] == {DEV_TYPE, strap_i}));

    // R7: silent while waiting after a NACK or a foreign address.
    a_r7_quiet_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> !drive_low_o);

endmodule

// File: rtl/spd_i2c_target.sv
// Top: presence-detect EEPROM target on a two-wire bus. Conditions both
// lines, runs the protocol engine and holds the 256-byte contents.
// sda_i must be the wired-AND bus level, including this block's drive.
module spd_i2c_target #(
    parameter int FILT_LEN    = 4,
    parameter int BUSY_CYCLES = 3_750_000,
    parameter int DEPTH       = 256,
    localparam int ADDR_W     = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    output logic       sda_drive_low_o
);
    logic [1:0]        raw_lines, filt_lines;
    logic [ADDR_W-1:0] ptr;
    logic              wr_en;
    logic [7:0]        wr_data, rd_data;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        spd_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_lines[g]),
            .filt_o (filt_lines[g])
        );
    end

    spd_proto_fsm #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_f_i     (filt_lines[1]),
        .sda_f_i     (filt_lines[0]),
        .strap_i     (strap_i),
        .rd_data_i   (rd_data),
        .ptr_o       (ptr),
        .wr_en_o     (wr_en),
        .wr_data_o   (wr_data),
        .drive_low_o (sda_drive_low_o)
    );

    spd_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .addr_i    (ptr),
        .wr_data_i (wr_data),
        .rd_data_o (rd_data)
    );

endmodule

// File: tb/spd_i2c_target_bench.sv
// Bench: behavioural bus master plus a reference model of the memory,
// pointer and busy window; the expected pull-down level is compared on
// every clock of each SCL-high window.
module spd_i2c_target_bench;
    localparam int Q    = 20;
    localparam int BUSY = 3000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       msda = 1'b1;
    logic [2:0] strap = 3'b101;
    logic       drv;
    logic       sda_bus;

    int    n_chk = 0, n_fail = 0, cyc = 0;
    logic  win = 1'b0, exp_low = 1'b0;
    string cur_req = "R1";
    logic [7:0] mdl_mem [256];
    int    mdl_ptr = 0;
    int    busy_until = 0;
    bit    mdl_wrote = 0, done = 0;

    assign sda_bus = msda & ~drv;

    spd_i2c_target #(.FILT_LEN(4), .BUSY_CYCLES(BUSY)) u_spd_i2c_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .strap_i(strap), .sda_drive_low_o(drv));

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Per-clock comparison of the pull-down enable against the model.
    always @(posedge clk) begin
        #1;
        if (win) begin
            n_chk++;
            if (drv !== exp_low) begin
                n_fail++;
                $display("FAIL %s cycle %0d drive actual=%b expected=%b", cur_req, cyc, drv, exp_low);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic clk_bit(input logic mb, input logic exp_drv, output logic seen);
        scl = 1'b0; tick(Q); msda = mb; tick(Q);
        scl = 1'b1; exp_low = exp_drv; tick(6); win = 1'b1;
        tick(Q - 6); seen = sda_bus; tick(Q - 6); win = 1'b0; tick(6);
    endtask

    task automatic bus_start();
        scl = 1'b0; tick(Q); msda = 1'b1; tick(Q);
        scl = 1'b1; tick(2 * Q); msda = 1'b0; tick(2 * Q);
    endtask

    task automatic bus_stop();
        scl = 1'b0; tick(Q); msda = 1'b0; tick(Q);
        scl = 1'b1; tick(2 * Q); msda = 1'b1; tick(2 * Q);
        if (mdl_wrote) busy_until = cyc + BUSY;
        mdl_wrote = 0;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], 1'b0, s);
        clk_bit(1'b1, exp_ack, s);
    endtask

    task automatic send_addr(input logic [6:0] a, input logic rd, output logic acked);
        acked = (a == {4'b1010, strap}) && (cyc + 8 * 4 * Q > busy_until);
        send_byte({a, rd}, acked);
    endtask

    task automatic read_byte(input logic mack, input logic active);
        logic [7:0] got, expb;
        logic s;
        expb = mdl_mem[mdl_ptr];
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, active & ~expb[i], s);
            got[i] = s;
        end
        clk_bit(~mack, 1'b0, s);
        if (active) begin
            check(cur_req, got, expb);
            mdl_ptr = (mdl_ptr + 1) % 256;
        end
    endtask

    task automatic set_ptr(input int p);
        logic a;
        bus_start(); send_addr(7'b1010101, 1'b0, a);
        send_byte(8'(p), 1'b1); mdl_ptr = p;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic a, s;
        logic [7:0] sum;
        // Model contents written from R2.
        for (int i = 0; i < 256; i++) mdl_mem[i] = (i >= 64) ? (8'(i) ^ 8'hA5) : 8'h00;
        mdl_mem[0] = 8'h80; mdl_mem[1] = 8'h08; mdl_mem[2] = 8'h02;
        mdl_mem[3] = 8'h0A; mdl_mem[4] = 8'h0A; mdl_mem[5] = 8'h01;
        mdl_mem[6] = 8'h40; mdl_mem[8] = 8'h01; mdl_mem[9] = 8'h3C;
        mdl_mem[10] = 8'h0F; mdl_mem[13] = 8'h10;
        sum = 8'h00;
        for (int i = 0; i < 63; i++) sum = sum + mdl_mem[i];
        mdl_mem[63] = sum;

        tick(8); rst_n = 1'b1;
        // R1: released after reset.
        cur_req = "R1"; exp_low = 1'b0; win = 1'b1; tick(20); win = 1'b0;

        // R3: bits clocked with no START are ignored.
        cur_req = "R3"; send_byte(8'hAA, 1'b0); tick(Q);

        // R10: a two-clock SDA dip with SCL high is no START.
        cur_req = "R10"; msda = 1'b0; tick(2); msda = 1'b1; tick(Q);
        send_byte(8'hAA, 1'b0); tick(Q);

        // R4: foreign address gets no acknowledge, then silence.
        cur_req = "R4"; bus_start(); send_addr(7'b1010000, 1'b0, a);
        check("R4", a, 0); send_byte(8'h00, 1'b0); bus_stop();

        // R1 R2 R6: read from reset pointer 0, ACK three, NACK the fourth.
        cur_req = "R6"; bus_start(); send_addr(7'b1010101, 1'b1, a);
        check("R1", a, 1);
        read_byte(1'b1, 1'b1); read_byte(1'b1, 1'b1);
        read_byte(1'b1, 1'b1); read_byte(1'b0, 1'b1);
        // R7: master NACKed; further clocks see no drive.
        cur_req = "R7"; read_byte(1'b1, 1'b0); bus_stop();

        // R2: checksum byte via pointer write + repeated START read.
        cur_req = "R2"; set_ptr(62); bus_start(); send_addr(7'b1010101, 1'b1, a);
        read_byte(1'b1, 1'b1); read_byte(1'b0, 1'b1); bus_stop();
        check("R2", mdl_mem[63], 8'h3B);

        // R5: pointer load then three stored bytes.
        cur_req = "R5"; set_ptr(10);
        for (int k = 0; k < 3; k++) begin
            send_byte(8'(8'h11 * (k + 1)), 1'b1);
            mdl_mem[mdl_ptr] = 8'(8'h11 * (k + 1)); mdl_ptr++; mdl_wrote = 1;
        end
        bus_stop();

        // R8: address ignored inside the busy window.
        cur_req = "R8"; bus_start(); send_addr(7'b1010101, 1'b0, a);
        check("R8", a, 0); bus_stop();
        tick(BUSY + 200);
        cur_req = "R5"; set_ptr(10); bus_start(); send_addr(7'b1010101, 1'b1, a);
        check("R8", a, 1);
        read_byte(1'b1, 1'b1); read_byte(1'b1, 1'b1); read_byte(1'b0, 1'b1); bus_stop();

        // R6: wrap from 255 to 0; pointer-only write starts no busy window.
        cur_req = "R6"; set_ptr(254); bus_stop();
        bus_start(); send_addr(7'b1010101, 1'b1, a); check("R6", a, 1);
        read_byte(1'b1, 1'b1); read_byte(1'b1, 1'b1);
        read_byte(1'b1, 1'b1); read_byte(1'b0, 1'b1); bus_stop();

        // R11: STOP after four bits of a data byte keeps earlier bytes only.
        cur_req = "R11"; set_ptr(100);
        send_byte(8'h77, 1'b1); mdl_mem[100] = 8'h77; mdl_ptr = 101; mdl_wrote = 1;
        for (int i = 0; i < 4; i++) clk_bit(1'b0, 1'b0, s);
        bus_stop();
        bus_start(); send_addr(7'b1010101, 1'b0, a); check("R11", a, 0); bus_stop();
        tick(BUSY + 200);
        set_ptr(100); bus_start(); send_addr(7'b1010101, 1'b1, a);
        read_byte(1'b1, 1'b1); read_byte(1'b0, 1'b1); bus_stop();

        tick(20);
        finish_run();
    end
endmodule